// File: doc/BRIEF.md
# Oversampled Serial Receiver with Receive Queue and Shared Interrupt

This block receives asynchronous serial frames on a single input line. It oversamples the line with a baud tick at sixteen ticks per bit and rebuilds each frame. It checks the stop bit and an optional parity bit, and it writes every received byte into a sixteen-entry receive queue. Each queue entry holds the byte together with its own framing-error and parity-error bits. A frame that carries an error is still stored, and the receiver then goes straight on to look for the next frame.

Four sticky status flags describe the receive side:
- The queue-level flag follows a programmable fill threshold.
- The error flag records any stored frame that had an error.
- The break flag records a frame in which the line stayed low throughout.
- The data-ready flag reports bytes that have been left in a partly filled queue while the line is idle.

Each flag has its own enable input. The enabled flags are ORed onto one interrupt output, so a single handler serves all four causes. Software reads the queue through a first-word-fall-through port with a pop strobe, and clears each flag with its own strobe.

Top module: `rxq_uart_top`

## Requirements
- R1: A frame is sampled at the middle of each bit. It is a low start bit, eight data bits with the least significant bit first, an optional parity bit, and one stop bit that is high. With parity off and a correct stop bit, the byte appears on `rd_data` with `rd_fe`=0 and `rd_pe`=0.
- R2: When `par_en`=1, one parity bit follows the data bits. With `par_odd`=0 the data bits and the parity bit must hold an even number of ones; with `par_odd`=1 they must hold an odd number. On a mismatch the stored entry has `rd_pe`=1. When `par_en`=0, `rd_pe` is always 0.
- R3: A stop bit sampled low stores the byte with `rd_fe`=1. The next frame after the line returns high is received normally.
- R4: A frame whose data bits, parity bit (when enabled) and stop bit are all 0 stores 0x00 with `rd_fe`=1 and sets `flag_brk`. The receiver waits for the line to go high before it looks for another start bit. `flag_brk` stays set until `clr_brk` is pulsed.
- R5: The queue holds 16 entries in arrival order. `rd_valid` is high while `fill` is not 0. A byte that arrives while 16 entries are held is dropped. A pop while the queue is empty has no effect.
- R6: `flag_full` sets when `fill` >= `trig_lvl` (valid range 1 to 16). A `clr_full` pulse has no effect while `fill` >= `trig_lvl`, and clears the flag once `fill` < `trig_lvl`.
- R7: `flag_err` sets when a frame with a framing or parity error is received. It stays set until `clr_err` is pulsed.
- R8: `flag_rdy` sets after the receiver has been idle for 15 bit times (240 ticks) while 0 < `fill` < `trig_lvl`. It stays set until `clr_rdy` is pulsed. After a clear it does not set again until the idle count restarts.
- R9: `irq` is high while any flag is set whose enable (`ien_full`, `ien_err`, `ien_brk`, `ien_rdy`) is 1. With all enables at 0, `irq` stays low.
- R10: A low pulse shorter than half a bit time is not taken as a start bit, and no entry is stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asynchronous |
| rxd | input | 1 | Serial receive line, idles high |
| tick16 | input | 1 | Baud tick, sixteen per bit time |
| par_en | input | 1 | Parity bit present |
| par_odd | input | 1 | 1 = odd parity, 0 = even parity |
| trig_lvl | input | 5 | Fill threshold for flag_full |
| ien_full | input | 1 | Interrupt enable for flag_full |
| ien_err | input | 1 | Interrupt enable for flag_err |
| ien_brk | input | 1 | Interrupt enable for flag_brk |
| ien_rdy | input | 1 | Interrupt enable for flag_rdy |
| clr_full | input | 1 | Clear strobe for flag_full |
| clr_err | input | 1 | Clear strobe for flag_err |
| clr_brk | input | 1 | Clear strobe for flag_brk |
| clr_rdy | input | 1 | Clear strobe for flag_rdy |
| rd_pop | input | 1 | Remove the head entry |
| rd_valid | output | 1 | Queue not empty |
| rd_data | output | 8 | Byte at the head of the queue |
| rd_fe | output | 1 | Framing error of the head entry |
| rd_pe | output | 1 | Parity error of the head entry |
| fill | output | 5 | Number of entries held |
| flag_full | output | 1 | Fill threshold flag |
| flag_err | output | 1 | Receive error flag |
| flag_brk | output | 1 | Break flag |
| flag_rdy | output | 1 | Idle data-ready flag |
| irq | output | 1 | Shared interrupt request |

## Verification
The bench sends all 256 byte values, so a data bit taken from the wrong place or sent in the wrong order would give a wrong byte. It sends good and bad parity in both parity modes, and a bad stop bit followed by a clean frame; a receiver that stopped after an error, or that flagged the wrong sense of parity, would lose or mislabel bytes. It sends a long break, a short low glitch, and an overflow of 17 frames. It also sweeps the threshold from 1 to 4 and tries clears that should be blocked. A design that counted the threshold one entry off, let a clear through too early, started a frame on a glitch, or wrote over the queue when it was full would fail these tests. The idle data-ready window is checked both before and after its 240-tick point.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
   localparam int BYTE_W = 8;
   localparam int NFLAG  = 4;
   // flag vector positions; the interrupt merge depends on them
   localparam int F_FULL = 0;
   localparam int F_ERR  = 1;
   localparam int F_BRK  = 2;
   localparam int F_RDY  = 3;

   typedef enum logic [2:0] {
      RX_IDLE, RX_START, RX_DATA, RX_PAR, RX_STOP, RX_HOLD
   } rx_state_e;

   typedef struct packed {
      logic [BYTE_W-1:0] data;
      logic              fe;
      logic              pe;
   } rx_entry_t;
endpackage

// File: rtl/rxq_sampler.sv
module rxq_sampler
   import rxq_pkg::*;
#(
   parameter int OVS         = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic      clk,
   input  logic      rst_n,
   input  logic      rxd,
   input  logic      tick,
   input  logic      par_en,
   input  logic      par_odd,
   output logic      busy,
   output logic      push,
   output rx_entry_t push_entry,
   output logic      push_brk
);
   localparam int CNT_W = $clog2(OVS);
   localparam logic [CNT_W-1:0] MID  = CNT_W'(OVS/2 - 1);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(OVS - 1);

   logic rxs;

   generate
      if (SYNC_STAGES == 0) begin : g_nosync
         assign rxs = rxd;
      end else begin : g_sync
         logic [SYNC_STAGES-1:0] sh;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sh <= '1;
            else        sh <= {sh[SYNC_STAGES-2 >= 0 ? SYNC_STAGES-2 : 0 : 0], rxd} & ({SYNC_STAGES{1'b1}});
         end
         assign rxs = sh[SYNC_STAGES-1];
      end
   endgenerate

   rx_state_e          state;
   logic [CNT_W-1:0]   cnt;
   logic [2:0]         bidx;
   logic [BYTE_W-1:0]  shreg;
   logic               pbit;
   logic               at_last;

   assign at_last = (cnt == LAST);
   assign busy    = (state != RX_IDLE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state      <= RX_IDLE;
         cnt        <= '0;
         bidx       <= '0;
         shreg      <= '0;
         pbit       <= 1'b0;
         push       <= 1'b0;
         push_entry <= '0;
         push_brk   <= 1'b0;
      end else begin
         push     <= 1'b0;
         push_brk <= 1'b0;
         if (state == RX_HOLD) begin
            if (rxs) state <= RX_IDLE;
         end else if (tick) begin
            case (state)
               RX_IDLE: begin
                  if (!rxs) begin
                     state <= RX_START;
                     cnt   <= '0;
                  end
               end
               RX_START: begin
                  if (cnt == MID) begin
                     cnt  <= '0;
                     bidx <= '0;
                     state <= rxs ? RX_IDLE : RX_DATA;
                  end else begin
                     cnt <= cnt + 1'b1;
                  end
               end
               RX_DATA: begin
                  cnt <= cnt + 1'b1;
                  if (at_last) begin
                     shreg <= {rxs, shreg[BYTE_W-1:1]};
                     bidx  <= bidx + 1'b1;
                     if (bidx == 3'd7) state <= par_en ? RX_PAR : RX_STOP;
                  end
               end
               RX_PAR: begin
                  cnt <= cnt + 1'b1;
                  if (at_last) begin
                     pbit  <= rxs;
                     state <= RX_STOP;
                  end
               end
               RX_STOP: begin
                  cnt <= cnt + 1'b1;
                  if (at_last) begin
                     push            <= 1'b1;
                     push_entry.data <= shreg;
                     push_entry.fe   <= !rxs;
                     push_entry.pe   <= par_en & (^shreg ^ pbit ^ par_odd);
                     push_brk        <= !rxs && (shreg == '0) && (!par_en || !pbit);
                     state           <= rxs ? RX_IDLE : RX_HOLD;
                  end
               end
               default: state <= RX_IDLE;
            endcase
         end
      end
   end
endmodule

// File: rtl/rxq_fifo.sv
module rxq_fifo #(
   parameter int DEPTH = 16,
   parameter int W     = 10,
   localparam int AW   = $clog2(DEPTH)
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         push,
   input  logic [W-1:0] wdata,
   input  logic         pop,
   output logic [W-1:0] rdata,
   output logic         valid,
   output logic [AW:0]  fill
);
   logic [W-1:0]  mem [DEPTH];
   logic [AW-1:0] wp, rp;
   logic          do_push, do_pop;

   assign do_push = push && (fill != (AW+1)'(DEPTH));
   assign do_pop  = pop && (fill != '0);
   assign valid   = (fill != '0);
   assign rdata   = mem[rp];

   always_ff @(posedge clk) begin
      if (do_push) mem[wp] <= wdata;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wp   <= '0;
         rp   <= '0;
         fill <= '0;
      end else begin
         if (do_push) wp <= wp + 1'b1;
         if (do_pop)  rp <= rp + 1'b1;
         case ({do_push, do_pop})
            2'b10:   fill <= fill + 1'b1;
            2'b01:   fill <= fill - 1'b1;
            default: fill <= fill;
         endcase
      end
   end
endmodule

// File: rtl/rxq_flags.sv
module rxq_flags
   import rxq_pkg::*;
#(
   parameter int FILL_W   = 5,
   parameter int DR_LIMIT = 240
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              busy,
   input  logic              push,
   input  logic              push_err,
   input  logic              push_brk,
   input  logic [FILL_W-1:0] fill,
   input  logic [FILL_W-1:0] trig,
   input  logic [NFLAG-1:0]  clr,
   output logic [NFLAG-1:0]  flags
);
   localparam int CW = $clog2(DR_LIMIT + 1);

   logic [CW-1:0]    idle_cnt;
   logic             counting, dr_hit, at_level;
   logic [NFLAG-1:0] set_v, hold_v;

   assign at_level = (fill >= trig);
   assign counting = !busy && (fill != '0) && !at_level;
   assign dr_hit   = counting && tick && (idle_cnt == CW'(DR_LIMIT - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                 idle_cnt <= '0;
      else if (!counting)                         idle_cnt <= '0;
      else if (tick && idle_cnt != CW'(DR_LIMIT)) idle_cnt <= idle_cnt + 1'b1;
   end

   always_comb begin
      set_v         = '0;
      hold_v        = '0;
      set_v[F_FULL] = at_level;
      hold_v[F_FULL]= at_level;
      set_v[F_ERR]  = push && push_err;
      set_v[F_BRK]  = push && push_brk;
      set_v[F_RDY]  = dr_hit;
   end

   for (genvar i = 0; i < NFLAG; i++) begin : g_flag
      logic q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) q <= 1'b0;
         else        q <= set_v[i] | (q & ~(clr[i] & ~hold_v[i]));
      end
      assign flags[i] = q;
   end
endmodule

// File: rtl/rxq_uart_top.sv
module rxq_uart_top
   import rxq_pkg::*;
#(
   parameter int DEPTH        = 16,
   parameter int OVS          = 16,
   parameter int SYNC_STAGES  = 2,
   parameter int DR_IDLE_BITS = 15
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    rxd,
   input  logic                    tick16,
   input  logic                    par_en,
   input  logic                    par_odd,
   input  logic [$clog2(DEPTH):0]  trig_lvl,
   input  logic                    ien_full,
   input  logic                    ien_err,
   input  logic                    ien_brk,
   input  logic                    ien_rdy,
   input  logic                    clr_full,
   input  logic                    clr_err,
   input  logic                    clr_brk,
   input  logic                    clr_rdy,
   input  logic                    rd_pop,
   output logic                    rd_valid,
   output logic [7:0]              rd_data,
   output logic                    rd_fe,
   output logic                    rd_pe,
   output logic [$clog2(DEPTH):0]  fill,
   output logic                    flag_full,
   output logic                    flag_err,
   output logic                    flag_brk,
   output logic                    flag_rdy,
   output logic                    irq
);
   localparam int FILL_W   = $clog2(DEPTH) + 1;
   localparam int ENTRY_W  = $bits(rx_entry_t);
   localparam int DR_LIMIT = DR_IDLE_BITS * OVS;

   if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("DEPTH must be a power of two of at least 2");
   end
   if (OVS < 4 || (OVS % 2) != 0 || (OVS & (OVS - 1)) != 0) begin : g_bad_ovs
      $error("OVS must be a power of two of at least 4");
   end
   if (SYNC_STAGES < 0 || SYNC_STAGES > 3) begin : g_bad_sync
      $error("SYNC_STAGES must be 0 to 3");
   end
   if (DR_IDLE_BITS < 1) begin : g_bad_idle
      $error("DR_IDLE_BITS must be at least 1");
   end

   logic       busy, push, push_brk;
   rx_entry_t  push_entry, head;
   logic [NFLAG-1:0] flags, clr_v, en_v;

   rxq_sampler #(.OVS(OVS), .SYNC_STAGES(SYNC_STAGES)) u_smp (
      .clk(clk), .rst_n(rst_n), .rxd(rxd), .tick(tick16),
      .par_en(par_en), .par_odd(par_odd), .busy(busy), .push(push),
      .push_entry(push_entry), .push_brk(push_brk)
   );

   rxq_fifo #(.DEPTH(DEPTH), .W(ENTRY_W)) u_fifo (
      .clk(clk), .rst_n(rst_n), .push(push), .wdata(push_entry),
      .pop(rd_pop), .rdata(head), .valid(rd_valid), .fill(fill)
   );

   assign clr_v = {clr_rdy, clr_brk, clr_err, clr_full};
   assign en_v  = {ien_rdy, ien_brk, ien_err, ien_full};

   rxq_flags #(.FILL_W(FILL_W), .DR_LIMIT(DR_LIMIT)) u_flags (
      .clk(clk), .rst_n(rst_n), .tick(tick16), .busy(busy), .push(push),
      .push_err(push_entry.fe | push_entry.pe), .push_brk(push_brk),
      .fill(fill), .trig(trig_lvl), .clr(clr_v), .flags(flags)
   );

   assign rd_data   = head.data;
   assign rd_fe     = head.fe;
   assign rd_pe     = head.pe;
   assign flag_full = flags[F_FULL];
   assign flag_err  = flags[F_ERR];
   assign flag_brk  = flags[F_BRK];
   assign flag_rdy  = flags[F_RDY];
   assign irq       = |(flags & en_v);
endmodule

// File: rtl/rxq_checker.sv
module rxq_checker #(
   parameter int DEPTH = 16
) (
   input logic                   clk,
   input logic                   rst_n,
   input logic [$clog2(DEPTH):0] fill,
   input logic [$clog2(DEPTH):0] trig_lvl,
   input logic                   flag_full,
   input logic                   flag_err,
   input logic                   flag_brk,
   input logic                   flag_rdy,
   input logic                   clr_err,
   input logic                   clr_brk,
   input logic                   ien_full,
   input logic                   ien_err,
   input logic                   ien_brk,
   input logic                   ien_rdy,
   input logic                   irq
);
   AST_FILL_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
      fill <= ($clog2(DEPTH)+1)'(DEPTH));                                // R5
   AST_FULL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_full && fill >= trig_lvl) |=> flag_full);                    // R6
   AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_err && !clr_err) |=> flag_err);                              // R7
   AST_BRK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_brk && !clr_brk) |=> flag_brk);                              // R4
   AST_RDY_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flag_rdy) |-> ($past(fill) != '0));                          // R8
   AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (!ien_full && !ien_err && !ien_brk && !ien_rdy) |-> !irq);         // R9
endmodule

bind rxq_uart_top rxq_checker #(.DEPTH(DEPTH)) u_chk (
   .clk(clk), .rst_n(rst_n), .fill(fill), .trig_lvl(trig_lvl),
   .flag_full(flag_full), .flag_err(flag_err), .flag_brk(flag_brk),
   .flag_rdy(flag_rdy), .clr_err(clr_err), .clr_brk(clr_brk),
   .ien_full(ien_full), .ien_err(ien_err), .ien_brk(ien_brk),
   .ien_rdy(ien_rdy), .irq(irq)
);

// File: tb/rxq_uart_top_test.sv
module rxq_uart_top_test;
   localparam int CLK_PERIOD = 10;
   localparam int OVS        = 16;
   localparam int WATCHDOG   = 190000;

   logic clk = 1'b0, rst_n = 1'b0, rxd = 1'b1;
   logic par_en = 1'b0, par_odd = 1'b0;
   logic [4:0] trig_lvl = 5'd16;
   logic ien_full = 0, ien_err = 0, ien_brk = 0, ien_rdy = 0;
   logic clr_full = 0, clr_err = 0, clr_brk = 0, clr_rdy = 0, rd_pop = 0;
   logic rd_valid, rd_fe, rd_pe, flag_full, flag_err, flag_brk, flag_rdy, irq;
   logic [7:0] rd_data;
   logic [4:0] fill;
   int total = 0, bad = 0, cycles = 0;
   bit done = 0;

   rxq_uart_top uut (
      .clk(clk), .rst_n(rst_n), .rxd(rxd), .tick16(1'b1), .par_en(par_en),
      .par_odd(par_odd), .trig_lvl(trig_lvl), .ien_full(ien_full),
      .ien_err(ien_err), .ien_brk(ien_brk), .ien_rdy(ien_rdy),
      .clr_full(clr_full), .clr_err(clr_err), .clr_brk(clr_brk),
      .clr_rdy(clr_rdy), .rd_pop(rd_pop), .rd_valid(rd_valid),
      .rd_data(rd_data), .rd_fe(rd_fe), .rd_pe(rd_pe), .fill(fill),
      .flag_full(flag_full), .flag_err(flag_err), .flag_brk(flag_brk),
      .flag_rdy(flag_rdy), .irq(irq)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   task automatic check(input string req, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wait_cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic drive_bit(input logic b);
      rxd = b;
      wait_cyc(OVS);
   endtask

   // pmode: 0 none, 1 correct parity, 2 wrong parity
   task automatic send_frame(input logic [7:0] d, input int pmode, input logic stopv);
      logic pb;
      pb = par_odd ? ~^d : ^d;
      if (pmode == 2) pb = ~pb;
      drive_bit(1'b0);
      for (int i = 0; i < 8; i++) drive_bit(d[i]);
      if (pmode != 0) drive_bit(pb);
      drive_bit(stopv);
   endtask

   task automatic pop_one();
      rd_pop = 1'b1;
      wait_cyc(1);
      rd_pop = 1'b0;
   endtask

   task automatic clear_all();
      {clr_full, clr_err, clr_brk, clr_rdy} = 4'hF;
      wait_cyc(1);
      {clr_full, clr_err, clr_brk, clr_rdy} = 4'h0;
   endtask

   task automatic drain();
      while (rd_valid) pop_one();
   endtask

   initial begin
      while (!done && cycles < WATCHDOG) begin
         @(posedge clk);
         cycles++;
      end
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog: actual=%0d expected=<%0d", cycles, WATCHDOG);
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      wait_cyc(4);
      rst_n = 1'b1;
      wait_cyc(2);
      // reset state
      check("R5 reset valid", rd_valid, 0);
      check("R5 reset fill", fill, 0);
      check("R9 reset flags", {flag_full, flag_err, flag_brk, flag_rdy, irq}, 0);

      // R1: every byte value, no parity
      for (int d = 0; d < 256; d++) begin
         send_frame(8'(d), 0, 1'b1);
         wait_cyc(4);
         check("R1 byte", {rd_valid, rd_data, rd_fe, rd_pe}, {1'b1, 8'(d), 2'b00});
         pop_one();
         wait_cyc(8);
      end
      check("R1 drained", fill, 0);

      // R2: both parity senses, good and bad parity bit
      par_en = 1'b1;
      for (int po = 0; po < 2; po++) begin
         par_odd = po[0];
         for (int d = 0; d < 256; d += 17) begin
            for (int bp = 0; bp < 2; bp++) begin
               send_frame(8'(d), bp + 1, 1'b1);
               wait_cyc(4);
               check("R2 parity", {rd_valid, rd_data, rd_fe, rd_pe},
                     {1'b1, 8'(d), 1'b0, bp[0]});
               pop_one();
               wait_cyc(8);
            end
         end
      end
      par_en = 1'b0;
      par_odd = 1'b0;

      // R7 / R9: error flag set and interrupt gating
      check("R7 err flag after bad parity", flag_err, 1);
      check("R9 masked irq", irq, 0);
      ien_err = 1'b1;
      wait_cyc(1);
      check("R9 enabled irq", irq, 1);
      wait_cyc(50);
      check("R7 err sticky", flag_err, 1);
      clear_all();
      check("R7 err cleared", {flag_err, irq}, 0);

      // R3: framing error then clean frame
      send_frame(8'hA5, 0, 1'b0);
      drive_bit(1'b1);
      send_frame(8'h3C, 0, 1'b1);
      wait_cyc(4);
      check("R3 fe entry", {rd_valid, rd_data, rd_fe, rd_pe}, {1'b1, 8'hA5, 2'b10});
      check("R7 err by fe", {flag_err, irq}, 2'b11);
      pop_one();
      check("R3 next frame", {rd_valid, rd_data, rd_fe, rd_pe}, {1'b1, 8'h3C, 2'b00});
      pop_one();
      ien_err = 1'b0;
      clear_all();

      // R4: long break, then normal frame
      send_frame(8'h00, 0, 1'b0);
      rxd = 1'b0;
      wait_cyc(3 * OVS);
      drive_bit(1'b1);
      check("R4 break entry", {fill, rd_data, rd_fe}, {5'd1, 8'h00, 1'b1});
      check("R4 break flag", flag_brk, 1);
      wait_cyc(100);
      check("R4 break sticky", flag_brk, 1);
      ien_brk = 1'b1;
      wait_cyc(1);
      check("R9 brk irq", irq, 1);
      clr_brk = 1'b1;
      wait_cyc(1);
      clr_brk = 1'b0;
      check("R4 break cleared", {flag_brk, irq}, 0);
      ien_brk = 1'b0;
      pop_one();
      send_frame(8'h81, 0, 1'b1);
      wait_cyc(4);
      check("R4 after break", {fill, rd_data, rd_fe}, {5'd1, 8'h81, 1'b0});
      pop_one();
      clear_all();

      // R10: short glitch is not a start bit
      rxd = 1'b0;
      wait_cyc(5);
      rxd = 1'b1;
      wait_cyc(3 * OVS);
      check("R10 glitch ignored", {rd_valid, fill}, 0);

      // R6: threshold sweep
      for (int t = 1; t <= 4; t++) begin
         trig_lvl = 5'(t);
         clear_all();
         for (int k = 0; k < t - 1; k++) send_frame(8'(k), 0, 1'b1);
         wait_cyc(4);
         check("R6 below level", {fill, flag_full}, {5'(t - 1), 1'b0});
         send_frame(8'h5A, 0, 1'b1);
         wait_cyc(4);
         check("R6 at level", {fill, flag_full}, {5'(t), 1'b1});
         ien_full = 1'b1;
         wait_cyc(1);
         check("R9 full irq", irq, 1);
         ien_full = 1'b0;
         clr_full = 1'b1;
         wait_cyc(1);
         clr_full = 1'b0;
         wait_cyc(1);
         check("R6 clear blocked", flag_full, 1);
         pop_one();
         clr_full = 1'b1;
         wait_cyc(1);
         clr_full = 1'b0;
         wait_cyc(1);
         check("R6 clear accepted", flag_full, 0);
         drain();
      end
      clear_all();

      // R5: order and overflow
      trig_lvl = 5'd16;
      for (int k = 0; k < 17; k++) send_frame(8'(8'h10 + k), 0, 1'b1);
      wait_cyc(4);
      check("R5 fill capped", fill, 16);
      for (int k = 0; k < 16; k++) begin
         check("R5 order", {rd_valid, rd_data}, {1'b1, 8'(8'h10 + k)});
         pop_one();
      end
      check("R5 overflow dropped", {rd_valid, fill}, 0);
      pop_one();
      check("R5 pop on empty", {rd_valid, fill}, 0);
      clear_all();

      // R8: idle data-ready window
      trig_lvl = 5'd4;
      send_frame(8'h77, 0, 1'b1);
      wait_cyc(200);
      check("R8 not yet", flag_rdy, 0);
      wait_cyc(50);
      check("R8 set after idle", flag_rdy, 1);
      ien_rdy = 1'b1;
      wait_cyc(1);
      check("R9 rdy irq", irq, 1);
      clr_rdy = 1'b1;
      wait_cyc(1);
      clr_rdy = 1'b0;
      wait_cyc(20);
      check("R8 stays clear", {flag_rdy, irq}, 0);
      ien_rdy = 1'b0;
      pop_one();

      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule